// File: doc/BRIEF.md
# Scratch Memory Window Router

This block sits between one processor's load/store port and the rest of the memory system. It holds two private scratch arrays. The code array answers every address below a programmable size. The data array answers a window whose base and size are both programmable. Byte, halfword and word reads and writes that land in a window are served locally. Every other access, including any access to a fixed boot-ROM region, is forwarded unchanged and combinationally to a downstream request port. A small register port loads the three window values.

The physical arrays are parameter-sized. The target chip sets `IMEM_IDX_W = 15` (32 KiB) and `DMEM_IDX_W = 14` (16 KiB). The defaults are smaller so that a plain build stays light. Each array is indexed by the low address bits only, so a window larger than its array sees the contents repeat. After reset both windows are disabled. Both arrays are then zeroed by a sweep that runs one word per cycle, and `busy` is high while the sweep runs.

Top module: `tcm_window_router`

## Requirements
- R1: A request hits the code array when it is outside the boot region and `req_addr < code_size`. The word index is `req_addr[IMEM_IDX_W-1:2]`, so contents repeat every 2^IMEM_IDX_W bytes across a larger window.
- R2: A request hits the data array when it is outside the boot region, misses the code window, and satisfies `data_base <= req_addr < data_base + data_size`. The word index is `(req_addr - data_base)[DMEM_IDX_W-1:2]`.
- R3: Priority runs from the boot region (`req_addr[31:BOOT_W] == BOOT_BASE[31:BOOT_W]`, always forwarded), to the code window, to the data window. Where the two windows overlap, the code array serves the access.
- R4: While `rst` is high and afterwards, code size and data size are 0 and the data base is all ones. Both arrays read as zero once the sweep ends. While `busy` is high, requests are ignored: no forwarding and no response.
- R5: `req_size` is 0 for a byte, 1 for a halfword and 2 for a word. Write data and read data are right-justified. Storage is little-endian: `req_addr[1:0]` picks the byte lane, `req_addr[1]` picks the halfword, and a word ignores both low bits.
- R6: A write that hits a window changes only the local array and raises no `ext_req_valid`. A request that misses both windows raises `ext_req_valid` in the same cycle, with the original address, size, write flag and write data.
- R7: A local read sets `rsp_valid` in the cycle after the request, carrying the read data. A forwarded read is answered by passing `ext_rsp_valid`/`ext_rsp_rdata` straight through to `rsp_valid`/`rsp_rdata`.
- R8: `cfg_we` with `cfg_sel` 0 loads the code size, 1 the data base, and 2 the data size. Value 3 is ignored. A new value steers requests from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Register select: 0 code size, 1 data base, 2 data size |
| cfg_wdata | input | ADDR_W | Register value |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Right-justified write data |
| busy | output | 1 | Array zeroing in progress; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Right-justified read data |
| ext_req_valid | output | 1 | Forwarded request valid |
| ext_write | output | 1 | Forwarded write flag |
| ext_size | output | 2 | Forwarded size |
| ext_addr | output | ADDR_W | Forwarded address |
| ext_wdata | output | 32 | Forwarded write data |
| ext_rsp_valid | input | 1 | Downstream read data valid |
| ext_rsp_rdata | input | 32 | Downstream read data |

## Verification
The checker watches the routing decision on every cycle. Boot-region requests must always be forwarded. Requests inside either window, computed here with an addition in place of the design's subtraction, must never be forwarded. `busy` must block forwarding. Every `rsp_valid` must trace back to a local read one cycle earlier or to a downstream response. Only the bench scenarios can show the stored values themselves: lane placement, the repetition of small arrays inside large windows, zeroed contents after reset, the overlap priority, and register changes taking effect one cycle later.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    CFG_CODE_SIZE = 2'd0,
    CFG_DATA_BASE = 2'd1,
    CFG_DATA_SIZE = 2'd2
  } cfg_sel_e;

  // Byte-lane enables for a naturally aligned little-endian access.
  function automatic logic [LANES-1:0] lane_enables(input logic [1:0] size,
                                                     input logic [1:0] off);
    logic [LANES-1:0] be;
    case (size)
      SZ_BYTE: be = 4'b0001 << off;
      SZ_HALF: be = off[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
    return be;
  endfunction

  // Spread right-justified write data across the lanes it may land in.
  function automatic logic [WORD_W-1:0] spread_wdata(input logic [1:0] size,
                                                      input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] w;
    case (size)
      SZ_BYTE: w = {4{d[7:0]}};
      SZ_HALF: w = {2{d[15:0]}};
      default: w = d;
    endcase
    return w;
  endfunction

  // Pick the addressed bytes out of a stored word and right-justify them.
  function automatic logic [WORD_W-1:0] pick_rdata(input logic [1:0] size,
                                                    input logic [1:0] off,
                                                    input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    case (size)
      SZ_BYTE: r = {24'd0, w[8*off +: 8]};
      SZ_HALF: r = off[1] ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
      default: r = w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs
  import tcm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] code_size,
  output logic [ADDR_W-1:0] data_base,
  output logic [ADDR_W-1:0] data_size
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_size <= '0;
      data_base <= '1;
      data_size <= '0;
    end else if (we) begin
      case (sel)
        CFG_CODE_SIZE: code_size <= wdata;
        CFG_DATA_BASE: data_base <= wdata;
        CFG_DATA_SIZE: data_size <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tcm_window_decode.sv
module tcm_window_decode #(
  parameter int              ADDR_W     = 32,
  parameter int              DMEM_IDX_W = 11,
  parameter int              BOOT_W     = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-1:0]       code_size,
  input  logic [ADDR_W-1:0]       data_base,
  input  logic [ADDR_W-1:0]       data_size,
  output logic                    boot_hit,
  output logic                    code_hit,
  output logic                    data_hit,
  output logic [DMEM_IDX_W-3:0]   data_widx
);
  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel       = addr - data_base;
    boot_hit  = (addr[ADDR_W-1:BOOT_W] == BOOT_BASE[ADDR_W-1:BOOT_W]);
    code_hit  = !boot_hit && (addr < code_size);
    data_hit  = !boot_hit && !code_hit && (addr >= data_base) && (rel < data_size);
    data_widx = rel[DMEM_IDX_W-1:2];
  end
endmodule

// File: rtl/tcm_bank.sv
module tcm_bank
  import tcm_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  output logic               clearing,
  input  logic               en,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic [IDX_W-3:0]   widx,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rword
);
  localparam int WIDX_W = IDX_W - 2;
  localparam int WORDS  = 1 << WIDX_W;
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(WORDS - 1);

  logic [WIDX_W-1:0] clr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_ptr  <= '0;
      clearing <= 1'b1;
    end else if (clearing) begin
      if (clr_ptr == LAST) clearing <= 1'b0;
      else                 clr_ptr  <= clr_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (clearing)
        mem[clr_ptr] <= 8'h00;
      else if (en && we && be[g])
        mem[widx] <= wdata[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (en && !we)
        rword[8*g +: 8] <= mem[widx];
    end
  end
endmodule

// File: rtl/tcm_window_router.sv
module tcm_window_router
  import tcm_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                IMEM_IDX_W = 12,
  parameter int                DMEM_IDX_W = 11,
  parameter int                BOOT_W     = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              ext_req_valid,
  output logic              ext_write,
  output logic [1:0]        ext_size,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [31:0]       ext_wdata,
  input  logic              ext_rsp_valid,
  input  logic [31:0]       ext_rsp_rdata
);
  logic [ADDR_W-1:0] cfg_code_size, cfg_data_base, cfg_data_size;
  logic boot_hit, code_hit, data_hit;
  logic [DMEM_IDX_W-3:0] data_widx;
  logic code_clr, data_clr;
  logic accept;
  logic [LANES-1:0]  be;
  logic [WORD_W-1:0] wspread, code_word, data_word;
  logic              rd_pend_q, rd_data_q;
  logic [1:0]        rd_size_q, rd_off_q;

  tcm_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .code_size(cfg_code_size), .data_base(cfg_data_base), .data_size(cfg_data_size)
  );

  tcm_window_decode #(
    .ADDR_W(ADDR_W), .DMEM_IDX_W(DMEM_IDX_W), .BOOT_W(BOOT_W), .BOOT_BASE(BOOT_BASE)
  ) u_dec (
    .addr(req_addr), .code_size(cfg_code_size), .data_base(cfg_data_base),
    .data_size(cfg_data_size), .boot_hit(boot_hit), .code_hit(code_hit),
    .data_hit(data_hit), .data_widx(data_widx)
  );

  assign busy    = code_clr | data_clr;
  assign accept  = req_valid && !busy;
  assign be      = lane_enables(req_size, req_addr[1:0]);
  assign wspread = spread_wdata(req_size, req_wdata);

  tcm_bank #(.IDX_W(IMEM_IDX_W)) u_code (
    .clk(clk), .rst(rst), .clearing(code_clr),
    .en(accept && code_hit), .we(req_write), .be(be),
    .widx(req_addr[IMEM_IDX_W-1:2]), .wdata(wspread), .rword(code_word)
  );

  tcm_bank #(.IDX_W(DMEM_IDX_W)) u_data (
    .clk(clk), .rst(rst), .clearing(data_clr),
    .en(accept && data_hit), .we(req_write), .be(be),
    .widx(data_widx), .wdata(wspread), .rword(data_word)
  );

  // Misses (boot region included) leave combinationally, unchanged.
  assign ext_req_valid = accept && !code_hit && !data_hit;
  assign ext_write     = req_write;
  assign ext_size      = req_size;
  assign ext_addr      = req_addr;
  assign ext_wdata     = req_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      rd_data_q <= 1'b0;
      rd_size_q <= SZ_WORD;
      rd_off_q  <= 2'd0;
    end else begin
      rd_pend_q <= accept && !req_write && (code_hit || data_hit);
      rd_data_q <= data_hit;
      rd_size_q <= req_size;
      rd_off_q  <= req_addr[1:0];
    end
  end

  assign rsp_valid = rd_pend_q || ext_rsp_valid;
  assign rsp_rdata = rd_pend_q ? pick_rdata(rd_size_q, rd_off_q,
                                            rd_data_q ? data_word : code_word)
                               : ext_rsp_rdata;
endmodule

// File: rtl/tcm_window_router_chk.sv
module tcm_window_router_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                BOOT_W    = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              rsp_valid,
  input logic              ext_req_valid,
  input logic              ext_rsp_valid,
  input logic [ADDR_W-1:0] code_size,
  input logic [ADDR_W-1:0] data_base,
  input logic [ADDR_W-1:0] data_size
);
  logic in_boot, in_code, in_data, live;
  assign live    = req_valid && !busy;
  assign in_boot = (req_addr[ADDR_W-1:BOOT_W] == BOOT_BASE[ADDR_W-1:BOOT_W]);
  assign in_code = !in_boot && (req_addr < code_size);
  assign in_data = !in_boot && (req_addr >= data_base) &&
                   ({1'b0, req_addr} < ({1'b0, data_base} + {1'b0, data_size}));

  // R3
  a_r3_boot_forwarded: assert property (@(posedge clk) disable iff (rst)
    live && in_boot |-> ext_req_valid);
  // R1
  a_r1_code_kept_local: assert property (@(posedge clk) disable iff (rst)
    live && in_code |-> !ext_req_valid);
  // R2
  a_r2_data_kept_local: assert property (@(posedge clk) disable iff (rst)
    live && in_data |-> !ext_req_valid);
  // R4
  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ext_req_valid);
  // R7
  a_r7_local_read_answers: assert property (@(posedge clk) disable iff (rst)
    live && !ext_req_valid && !req_write |=> rsp_valid);
  // R7
  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !ext_rsp_valid |-> $past(live && !ext_req_valid && !req_write));
endmodule

bind tcm_window_router tcm_window_router_chk #(
  .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .BOOT_BASE(BOOT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .busy(busy), .rsp_valid(rsp_valid),
  .ext_req_valid(ext_req_valid), .ext_rsp_valid(ext_rsp_valid),
  .code_size(cfg_code_size), .data_base(cfg_data_base), .data_size(cfg_data_size)
);

// File: tb/tcm_window_router_test.sv
`timescale 1ns/1ps
module tcm_window_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        busy, rsp_valid, ext_req_valid, ext_write;
  logic [31:0] rsp_rdata, ext_addr, ext_wdata;
  logic [1:0]  ext_size;
  logic        ext_rsp_valid = 1'b0;
  logic [31:0] ext_rsp_rdata = '0;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  tcm_window_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ext_req_valid(ext_req_valid),
    .ext_write(ext_write), .ext_size(ext_size), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rsp_valid(ext_rsp_valid), .ext_rsp_rdata(ext_rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] data;
    logic        loc;
    logic [31:0] exp;
  } vec_t;

  // Config during the table: code size 0x2000, data base 0x0080_0000, data size 0x800.
  // Defaults: code array 4 KiB (repeats every 0x1000), data array 2 KiB.
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 32'h0000_0010, 32'hA1B2_C3D4, 1'b1, 32'h0},          // R1 R6 word write
    '{1'b0, 2'd2, 32'h0000_0010, 32'h0,         1'b1, 32'hA1B2_C3D4},  // R1 R7
    '{1'b0, 2'd0, 32'h0000_0011, 32'h0,         1'b1, 32'h0000_00C3},  // R5 byte lane 1
    '{1'b0, 2'd1, 32'h0000_0012, 32'h0,         1'b1, 32'h0000_A1B2},  // R5 upper half
    '{1'b1, 2'd0, 32'h0000_0013, 32'h0000_005E, 1'b1, 32'h0},          // R5 byte write lane 3
    '{1'b0, 2'd2, 32'h0000_0010, 32'h0,         1'b1, 32'h5EB2_C3D4},  // R5
    '{1'b0, 2'd2, 32'h0000_1010, 32'h0,         1'b1, 32'h5EB2_C3D4},  // R1 repeat
    '{1'b1, 2'd1, 32'h0080_0006, 32'h0000_7788, 1'b1, 32'h0},          // R2 half write
    '{1'b0, 2'd2, 32'h0080_0004, 32'h0,         1'b1, 32'h7788_0000},  // R2 index
    '{1'b0, 2'd0, 32'h0080_0007, 32'h0,         1'b1, 32'h0000_0077},  // R2 R5
    '{1'b0, 2'd2, 32'h0080_0800, 32'h0,         1'b0, 32'h0BAD_0001},  // R2 top edge miss
    '{1'b0, 2'd2, 32'h007F_FFFC, 32'h0,         1'b0, 32'h0BAD_0002},  // R2 below base miss
    '{1'b0, 2'd2, 32'h0000_2000, 32'h0,         1'b0, 32'h0BAD_0003},  // R1 edge miss
    '{1'b1, 2'd2, 32'h0200_0000, 32'hCAFE_F00D, 1'b0, 32'h0}           // R6 forwarded write
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string tag, input logic wr, input logic [1:0] sz,
                        input logic [31:0] addr, input logic [31:0] data,
                        input logic loc, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = data;
    #1;
    check({tag, " R6 forward flag"}, {31'd0, ext_req_valid}, {31'd0, !loc});
    if (!loc) begin
      check({tag, " R6 fwd addr"}, ext_addr, addr);
      check({tag, " R6 fwd write/size"}, {29'd0, ext_write, ext_size}, {29'd0, wr, sz});
      if (wr) check({tag, " R6 fwd data"}, ext_wdata, data);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr && !loc) begin
      ext_rsp_valid = 1'b1; ext_rsp_rdata = exp;
    end
    #1;
    check({tag, " R7 rsp_valid"}, {31'd0, rsp_valid}, {31'd0, !wr});
    if (!wr) check({tag, " R7 rdata"}, rsp_rdata, exp);
    ext_rsp_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R4 busy after reset", {31'd0, busy}, 32'd1);
    check("R4 no rsp after reset", {31'd0, rsp_valid}, 32'd0);
    // Request during the sweep is ignored, even for a boot address.
    req_valid = 1'b1; req_addr = 32'hFFFF_0000; req_write = 1'b0; req_size = 2'd2;
    #1;
    check("R4 busy ignores request", {31'd0, ext_req_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R4 busy gives no rsp", {31'd0, rsp_valid}, 32'd0);
    begin
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      check("R4 sweep ends", {31'd0, busy}, 32'd0);
    end

    // Windows disabled after reset: everything is forwarded.
    access("R4 code window off", 1'b0, 2'd2, 32'h0000_0000, 32'h0, 1'b0, 32'h1234_0000);
    access("R4 data window off", 1'b0, 2'd2, 32'hFFFF_FFFC, 32'h0, 1'b0, 32'h1234_0001);

    // R8: a value written applies from the next cycle.
    cfg(2'd0, 32'h0000_2000);
    cfg(2'd1, 32'h0080_0000);
    cfg(2'd2, 32'h0000_0800);
    cfg(2'd3, 32'h0000_0000); // R8 select 3 ignored: code window stays at 0x2000
    access("R4 cleared code array", 1'b0, 2'd2, 32'h0000_0040, 32'h0, 1'b1, 32'h0);
    access("R4 cleared data array", 1'b0, 2'd2, 32'h0080_0100, 32'h0, 1'b1, 32'h0);

    for (int i = 0; i < NV; i++)
      access($sformatf("vec%0d", i), VECS[i].wr, VECS[i].sz, VECS[i].addr,
             VECS[i].data, VECS[i].loc, VECS[i].exp);

    // R3: overlapping windows, the code array wins.
    cfg(2'd1, 32'h0000_0000);
    cfg(2'd2, 32'h0000_0100);
    access("R3 overlap code wins", 1'b0, 2'd2, 32'h0000_0010, 32'h0, 1'b1, 32'h5EB2_C3D4);
    access("R3 overlap write", 1'b1, 2'd2, 32'h0000_0020, 32'h1111_2222, 1'b1, 32'h0);
    cfg(2'd0, 32'h0000_0000);
    access("R3 R8 data after code off", 1'b0, 2'd2, 32'h0000_0020, 32'h0, 1'b1, 32'h0);
    access("R2 R8 moved base", 1'b0, 2'd1, 32'h0080_0006, 32'h0, 1'b0, 32'h0000_4242);

    // R3: boot region beats a code window that covers everything.
    cfg(2'd0, 32'hFFFF_FFFF);
    access("R3 boot forwarded", 1'b0, 2'd2, 32'hFFFF_0010, 32'h0, 1'b0, 32'h0B00_7000);
    access("R1 R3 just below boot", 1'b0, 2'd2, 32'hFFFE_0010, 32'h0, 1'b1, 32'h5EB2_C3D4);
    access("R1 repeat overlap write seen", 1'b0, 2'd2, 32'h0000_1020, 32'h0, 1'b1, 32'h1111_2222);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule